// File: doc/BRIEF.md
# Window Read Forwarding Sequencer

This block sits in an I/O bridge port between a system bus on one side and a pair of links to remote adapter nodes on the other: one link leads downstream to the nodes and one returns upstream from them. A bus read aimed at the window space of a remote node is handled as a split transaction. The port answers the bus on the next cycle with filler data. It records the requester's ID and queues a sparse or dense window read packet for the downstream link.

When a packet leaves the queue, the port posts a decrement-queue write in broadcast space and charges a downstream credit for that node. Return packets from the upstream link are matched to outstanding reads in issue order. Each one becomes a broadcast write that carries the requester's ID in the bank field. A clean return goes to the return-data register with its data. A return flagged as errored goes to the return-error register with zero data. Returns also charge an upstream credit for their node. Credit counters never wrap below zero: a decrement at zero leaves the count at zero and sets a sticky underflow flag. A separate release input gives credits back.

Top module: `wrfs_seq`

## Requirements
- R1: A read whose node number lies in 4..8 (NODE_LO to NODE_LO+NODES-1) is accepted. A read to any other node gets no response, queues nothing and leaves the credits unchanged.
- R2: One cycle after an accepted read, rsp_valid is high, rsp_retry is low and rsp_data is all zeros.
- R3: With DEPTH (4) reads outstanding, a further in-window read is refused. One cycle later rsp_retry is high and rsp_valid is low, and no packet is added.
- R4: Queued packets leave on the downstream link in acceptance order. Each presents the read's dense flag, node and address on dn_dense, dn_node and dn_addr while dn_valid is high. A packet leaves in a cycle where dn_valid and dn_ready are both high.
- R5: The cycle after a packet leaves, bw_valid is high with bw_kind = 0 (decrement-queue), bw_bank = that packet's node and bw_data = 0.
- R6: A clean return (up_err = 0) produces, one cycle after it is taken, a broadcast write with bw_kind = 1 (return-data), bw_bank = the requester ID and bw_data = up_data.
- R7: An errored return (up_err = 1) produces, one cycle after it is taken, a broadcast write with bw_kind = 2 (return-error), bw_bank = the requester ID and bw_data = 0.
- R8: Returns are matched to outstanding reads oldest first, so the bank field of successive return writes follows the order in which the reads were accepted.
- R9: Each node has a downstream credit and an upstream credit, both starting at CRED_INIT (4). The credit for node n is held in bits [(n-4)*CW +: CW] of dn_credits or up_credits. A departing packet takes one from dn_credits of its node. A taken return takes one from up_credits of up_node. A cr_rel_valid pulse adds one to the counter picked by cr_rel_up (1 = upstream) and cr_rel_node, saturating at 2^CW-1.
- R10: A decrement of a counter that is already zero leaves it at zero and sets cred_underflow. The flag stays set until reset, including after later releases.
- R11: A packet leaving and a return being taken never happen in the same cycle; the departure wins. up_ready is low whenever no read is outstanding or dn_valid and dn_ready are both high.
- R12: After reset rsp_valid, rsp_retry, dn_valid, up_ready, bw_valid and cred_underflow are low and every credit equals CRED_INIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_valid | input | 1 | Bus read to window space presented |
| rd_node | input | 4 | Target node number |
| rd_dense | input | 1 | 1 = dense window read, 0 = sparse |
| rd_vid | input | 4 | Requester ID |
| rd_addr | input | AW | Window address |
| rsp_valid | output | 1 | Immediate bus response (filler data) |
| rsp_retry | output | 1 | Read refused, tracking full |
| rsp_data | output | DW | Filler response data (zero) |
| dn_valid | output | 1 | Downstream packet available |
| dn_ready | input | 1 | Downstream link takes the packet |
| dn_dense | output | 1 | Packet type |
| dn_node | output | 4 | Packet target node |
| dn_addr | output | AW | Packet address |
| up_valid | input | 1 | Upstream return packet presented |
| up_ready | output | 1 | Return packet is taken this cycle |
| up_err | input | 1 | Return packet failed its integrity check |
| up_node | input | 4 | Node the return came from |
| up_data | input | DW | Returned read data |
| cr_rel_valid | input | 1 | Credit release pulse |
| cr_rel_up | input | 1 | 1 = upstream counter, 0 = downstream |
| cr_rel_node | input | 4 | Node whose credit is released |
| bw_valid | output | 1 | Broadcast write issued |
| bw_kind | output | 2 | 0 decrement-queue, 1 return-data, 2 return-error |
| bw_bank | output | 4 | Bank field: node or requester ID |
| bw_data | output | DW | First data cycle of the write |
| dn_credits | output | NODES*CW | Downstream credit counters, packed |
| up_credits | output | NODES*CW | Upstream credit counters, packed |
| cred_underflow | output | 1 | Sticky credit underflow |

## Verification
The hardest case to reach is a cycle where a packet is ready to leave and a return arrives at the same time, because a return only counts when a read is still outstanding. The stimulus queues two reads and holds both back. It then raises dn_ready and up_valid on the same edge and watches up_ready stay low and the decrement-queue write come out first. The return data write follows on the next cycle. Underflow needs a counter to be drained to zero, so the bench repeats full read, send and return round trips on one node while keeping its own saturating credit model.

// File: rtl/wrfs_pkg.sv
package wrfs_pkg;

  typedef enum logic [1:0] {
    BW_DECQ  = 2'd0,
    BW_RDATA = 2'd1,
    BW_RERR  = 2'd2
  } bw_kind_e;

  // true when node falls in the remote window range [lo, lo+n-1]
  function automatic logic in_window(input logic [3:0] node,
                                     input int unsigned lo,
                                     input int unsigned n);
    return (int'(node) >= int'(lo)) && (int'(node) < int'(lo + n));
  endfunction

endpackage

// File: rtl/wrfs_fifo.sv
module wrfs_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = PW + 1;

  logic [W-1:0]    mem [DEPTH];
  logic [PW-1:0]   wp, rp;
  logic [CNTW-1:0] cnt;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  assign empty = (cnt == '0);
  assign full  = (int'(cnt) == DEPTH);
  assign head  = mem[rp];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= ptr_inc(wp);
      if (pop)  rp <= ptr_inc(rp);
      cnt <= cnt + CNTW'(push) - CNTW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end
endmodule

// File: rtl/wrfs_credits.sv
module wrfs_credits #(
  parameter int NODES = 5,
  parameter int CW    = 3,
  parameter int INIT  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                dec_valid,
  input  logic [3:0]          dec_idx,
  input  logic                inc_valid,
  input  logic [3:0]          inc_idx,
  output logic [NODES*CW-1:0] counts,
  output logic                underflow
);
  localparam logic [CW-1:0] CMAX = '1;

  // {underflow, next count}
  function automatic logic [CW:0] cred_step(input logic [CW-1:0] cur,
                                            input logic dec, input logic inc);
    if (dec && !inc)
      return (cur == '0) ? {1'b1, cur} : {1'b0, cur - 1'b1};
    else if (inc && !dec)
      return (cur == CMAX) ? {1'b0, cur} : {1'b0, cur + 1'b1};
    else
      return {1'b0, cur};
  endfunction

  logic [NODES-1:0] uf_vec;
  logic             uf_q;

  for (genvar i = 0; i < NODES; i++) begin : g_node
    logic [CW-1:0] cnt_q;
    logic [CW:0]   step;
    assign step = cred_step(cnt_q,
                            dec_valid && (int'(dec_idx) == i),
                            inc_valid && (int'(inc_idx) == i));
    assign uf_vec[i] = step[CW];
    assign counts[i*CW +: CW] = cnt_q;
    always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= CW'(INIT);
      else        cnt_q <= step[CW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) uf_q <= 1'b0;
    else        uf_q <= uf_q | (|uf_vec);
  end
  assign underflow = uf_q;
endmodule

// File: rtl/wrfs_seq.sv
module wrfs_seq
  import wrfs_pkg::*;
#(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int DEPTH     = 4,
  parameter int CW        = 3,
  parameter int CRED_INIT = 4,
  parameter int NODE_LO   = 4,
  parameter int NODES     = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_valid,
  input  logic [3:0]          rd_node,
  input  logic                rd_dense,
  input  logic [3:0]          rd_vid,
  input  logic [AW-1:0]       rd_addr,
  output logic                rsp_valid,
  output logic                rsp_retry,
  output logic [DW-1:0]       rsp_data,
  output logic                dn_valid,
  input  logic                dn_ready,
  output logic                dn_dense,
  output logic [3:0]          dn_node,
  output logic [AW-1:0]       dn_addr,
  input  logic                up_valid,
  output logic                up_ready,
  input  logic                up_err,
  input  logic [3:0]          up_node,
  input  logic [DW-1:0]       up_data,
  input  logic                cr_rel_valid,
  input  logic                cr_rel_up,
  input  logic [3:0]          cr_rel_node,
  output logic                bw_valid,
  output logic [1:0]          bw_kind,
  output logic [3:0]          bw_bank,
  output logic [DW-1:0]       bw_data,
  output logic [NODES*CW-1:0] dn_credits,
  output logic [NODES*CW-1:0] up_credits,
  output logic                cred_underflow
);
  localparam int PKT_W = 1 + 4 + AW;
  localparam logic [3:0] LO4 = 4'(NODE_LO);

  // named internal events
  logic rd_hit, rd_accept, rd_reject, dn_fire, ret_fire;
  logic vid_empty, vid_full, pkt_empty, pkt_full;
  logic [PKT_W-1:0] pkt_head;
  logic [3:0]       vid_head;

  assign rd_hit    = rd_valid && in_window(rd_node, NODE_LO, NODES);
  assign rd_accept = rd_hit && !vid_full;
  assign rd_reject = rd_hit && vid_full;

  assign dn_valid = !pkt_empty;
  assign dn_fire  = dn_valid && dn_ready;
  assign up_ready = !vid_empty && !dn_fire;
  assign ret_fire = up_valid && up_ready;

  assign {dn_dense, dn_node, dn_addr} = pkt_head;

  wrfs_fifo #(.W(PKT_W), .DEPTH(DEPTH)) u_pkt_q (
    .clk(clk), .rst_n(rst_n),
    .push(rd_accept), .din({rd_dense, rd_node, rd_addr}),
    .pop(dn_fire), .head(pkt_head), .empty(pkt_empty), .full(pkt_full)
  );

  wrfs_fifo #(.W(4), .DEPTH(DEPTH)) u_vid_q (
    .clk(clk), .rst_n(rst_n),
    .push(rd_accept), .din(rd_vid),
    .pop(ret_fire), .head(vid_head), .empty(vid_empty), .full(vid_full)
  );

  // immediate split response
  assign rsp_data = '0;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_retry <= 1'b0;
    end else begin
      rsp_valid <= rd_accept;
      rsp_retry <= rd_reject;
    end
  end

  // broadcast write generation, departure first
  bw_kind_e bw_kind_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bw_valid  <= 1'b0;
      bw_kind_q <= BW_DECQ;
      bw_bank   <= '0;
      bw_data   <= '0;
    end else begin
      bw_valid <= dn_fire || ret_fire;
      if (dn_fire) begin
        bw_kind_q <= BW_DECQ;
        bw_bank   <= dn_node;
        bw_data   <= '0;
      end else if (ret_fire) begin
        bw_kind_q <= up_err ? BW_RERR : BW_RDATA;
        bw_bank   <= vid_head;
        bw_data   <= up_err ? '0 : up_data;
      end
    end
  end
  assign bw_kind = bw_kind_q;

  // credit tracking
  logic uf_dn, uf_up;

  wrfs_credits #(.NODES(NODES), .CW(CW), .INIT(CRED_INIT)) u_dn_cred (
    .clk(clk), .rst_n(rst_n),
    .dec_valid(dn_fire), .dec_idx(dn_node - LO4),
    .inc_valid(cr_rel_valid && !cr_rel_up), .inc_idx(cr_rel_node - LO4),
    .counts(dn_credits), .underflow(uf_dn)
  );

  wrfs_credits #(.NODES(NODES), .CW(CW), .INIT(CRED_INIT)) u_up_cred (
    .clk(clk), .rst_n(rst_n),
    .dec_valid(ret_fire), .dec_idx(up_node - LO4),
    .inc_valid(cr_rel_valid && cr_rel_up), .inc_idx(cr_rel_node - LO4),
    .counts(up_credits), .underflow(uf_up)
  );

  assign cred_underflow = uf_dn | uf_up;
endmodule

// File: rtl/wrfs_chk.sv
module wrfs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_accept,
  input logic       rd_reject,
  input logic       dn_fire,
  input logic       ret_fire,
  input logic       up_err,
  input logic       up_ready,
  input logic       vid_empty,
  input logic       rsp_valid,
  input logic       rsp_retry,
  input logic       bw_valid,
  input logic [1:0] bw_kind,
  input logic       cred_underflow
);
  p_ack_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_accept |=> rsp_valid && !rsp_retry);

  p_retry_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_reject |=> rsp_retry && !rsp_valid);

  p_decq_after_send_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dn_fire |=> bw_valid && bw_kind == 2'd0);

  p_good_return_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_fire && !up_err) |=> bw_valid && bw_kind == 2'd1);

  p_err_return_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_fire && up_err) |=> bw_valid && bw_kind == 2'd2);

  p_sticky_underflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cred_underflow |=> cred_underflow);

  p_no_dual_fire_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(dn_fire && ret_fire));

  p_no_ready_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    vid_empty |-> !up_ready);

  p_quiet_bus_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!dn_fire && !ret_fire) |=> !bw_valid);
endmodule

bind wrfs_seq wrfs_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .rd_accept(rd_accept), .rd_reject(rd_reject),
  .dn_fire(dn_fire), .ret_fire(ret_fire), .up_err(up_err),
  .up_ready(up_ready), .vid_empty(vid_empty),
  .rsp_valid(rsp_valid), .rsp_retry(rsp_retry),
  .bw_valid(bw_valid), .bw_kind(bw_kind),
  .cred_underflow(cred_underflow)
);

// File: tb/wrfs_seq_tb.sv
module wrfs_seq_tb;
  localparam int AW = 32, DW = 32, CW = 3, NODES = 5, INIT = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rd_valid = 0, rd_dense = 0;
  logic [3:0] rd_node = 0, rd_vid = 0;
  logic [AW-1:0] rd_addr = 0;
  logic rsp_valid, rsp_retry;
  logic [DW-1:0] rsp_data;
  logic dn_valid, dn_ready = 0, dn_dense;
  logic [3:0] dn_node;
  logic [AW-1:0] dn_addr;
  logic up_valid = 0, up_ready, up_err = 0;
  logic [3:0] up_node = 0;
  logic [DW-1:0] up_data = 0;
  logic cr_rel_valid = 0, cr_rel_up = 0;
  logic [3:0] cr_rel_node = 0;
  logic bw_valid;
  logic [1:0] bw_kind;
  logic [3:0] bw_bank;
  logic [DW-1:0] bw_data;
  logic [NODES*CW-1:0] dn_credits, up_credits;
  logic cred_underflow;

  int total = 0, bad = 0;
  int exp_dn[NODES], exp_up[NODES];
  logic exp_uf = 1'b0;

  always #5 clk = ~clk;

  wrfs_seq u_dut (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void model_dec(input bit up, input int node);
    int i = node - 4;
    if (up) begin
      if (exp_up[i] == 0) exp_uf = 1'b1; else exp_up[i]--;
    end else begin
      if (exp_dn[i] == 0) exp_uf = 1'b1; else exp_dn[i]--;
    end
  endfunction

  function automatic logic [NODES*CW-1:0] pack(input bit up);
    logic [NODES*CW-1:0] v;
    for (int i = 0; i < NODES; i++) v[i*CW +: CW] = CW'(up ? exp_up[i] : exp_dn[i]);
    return v;
  endfunction

  task automatic check_credits(input string tag);
    check({tag, " R9 dn credits"}, 64'(dn_credits), 64'(pack(0)));
    check({tag, " R9 up credits"}, 64'(up_credits), 64'(pack(1)));
    check({tag, " R10 underflow"}, 64'(cred_underflow), 64'(exp_uf));
  endtask

  // issue one read; expect accepted (1), refused (2) or ignored (0)
  task automatic do_read(input logic [3:0] node, input logic dense,
                         input logic [3:0] vid, input logic [AW-1:0] addr, input int outcome);
    @(negedge clk);
    rd_valid = 1; rd_node = node; rd_dense = dense; rd_vid = vid; rd_addr = addr;
    @(negedge clk);
    rd_valid = 0;
    check("R2/R3/R1 rsp_valid", 64'(rsp_valid), 64'(outcome == 1));
    check("R3/R1 rsp_retry", 64'(rsp_retry), 64'(outcome == 2));
    if (outcome == 1) check("R2 rsp_data zero", 64'(rsp_data), 64'd0);
  endtask

  task automatic do_send(input logic [3:0] node, input logic dense, input logic [AW-1:0] addr);
    @(negedge clk);
    check("R4 dn_valid", 64'(dn_valid), 64'd1);
    check("R4 dn_node", 64'(dn_node), 64'(node));
    check("R4 dn_dense", 64'(dn_dense), 64'(dense));
    check("R4 dn_addr", 64'(dn_addr), 64'(addr));
    dn_ready = 1;
    @(negedge clk);
    dn_ready = 0;
    model_dec(0, node);
    check("R5 bw_valid", 64'(bw_valid), 64'd1);
    check("R5 bw_kind decq", 64'(bw_kind), 64'd0);
    check("R5 bw_bank node", 64'(bw_bank), 64'(node));
    check("R5 bw_data", 64'(bw_data), 64'd0);
  endtask

  task automatic do_return(input logic [3:0] node, input logic err,
                           input logic [DW-1:0] data, input logic [3:0] exp_vid);
    @(negedge clk);
    up_valid = 1; up_node = node; up_err = err; up_data = data;
    #1;
    check("R11 up_ready with outstanding", 64'(up_ready), 64'd1);
    @(negedge clk);
    up_valid = 0;
    model_dec(1, node);
    check("R6/R7 bw_valid", 64'(bw_valid), 64'd1);
    check(err ? "R7 bw_kind err" : "R6 bw_kind data", 64'(bw_kind), err ? 64'd2 : 64'd1);
    check("R8 bw_bank requester", 64'(bw_bank), 64'(exp_vid));
    check(err ? "R7 bw_data zero" : "R6 bw_data", 64'(bw_data), err ? 64'd0 : 64'(data));
  endtask

  task automatic t_reset;
    check("R12 rsp_valid", 64'(rsp_valid), 0);
    check("R12 rsp_retry", 64'(rsp_retry), 0);
    check("R12 dn_valid", 64'(dn_valid), 0);
    check("R12 up_ready", 64'(up_ready), 0);
    check("R12 bw_valid", 64'(bw_valid), 0);
    check_credits("R12");
  endtask

  task automatic t_window;
    do_read(4'd3, 0, 4'd1, 32'h100, 0);
    do_read(4'd9, 1, 4'd1, 32'h104, 0);
    check("R1 nothing queued", 64'(dn_valid), 0);
    check_credits("R1");
    do_read(4'd4, 1, 4'd7, 32'hA000_0040, 1);
    do_send(4'd4, 1, 32'hA000_0040);
    check_credits("R9 send");
    do_return(4'd4, 0, 32'hDEAD_BEEF, 4'd7);
    check_credits("R9 return");
  endtask

  task automatic t_order;
    do_read(4'd5, 0, 4'd1, 32'h10, 1);
    do_read(4'd6, 1, 4'd2, 32'h20, 1);
    do_read(4'd8, 0, 4'd3, 32'h30, 1);
    do_read(4'd7, 1, 4'd9, 32'h40, 1);
    do_read(4'd5, 0, 4'd4, 32'h50, 2);
    do_send(4'd5, 0, 32'h10);
    do_send(4'd6, 1, 32'h20);
    do_send(4'd8, 0, 32'h30);
    do_send(4'd7, 1, 32'h40);
    @(negedge clk);
    check("R3 refused read not queued", 64'(dn_valid), 0);
    do_return(4'd5, 0, 32'h1111, 4'd1);
    do_return(4'd6, 1, 32'h2222, 4'd2);
    do_return(4'd8, 0, 32'h3333, 4'd3);
    do_return(4'd7, 0, 32'h4444, 4'd9);
    @(negedge clk);
    up_valid = 1; #1;
    check("R11 up_ready low when idle", 64'(up_ready), 0);
    @(negedge clk);
    up_valid = 0;
    check("R11 no write on idle return", 64'(bw_valid), 0);
    check_credits("R9 order");
  endtask

  task automatic t_priority;
    do_read(4'd6, 0, 4'd5, 32'h60, 1);
    do_read(4'd6, 1, 4'd6, 32'h64, 1);
    @(negedge clk);
    dn_ready = 1; up_valid = 1; up_node = 4'd6; up_err = 0; up_data = 32'hCAFE;
    #1;
    check("R11 up_ready low during send", 64'(up_ready), 0);
    @(negedge clk);
    dn_ready = 0;
    model_dec(0, 6);
    check("R11 decq first", 64'(bw_kind), 0);
    #1;
    check("R11 up_ready after send", 64'(up_ready), 1);
    @(negedge clk);
    up_valid = 0;
    model_dec(1, 6);
    check("R11 return next", 64'(bw_kind), 1);
    check("R8 oldest vid", 64'(bw_bank), 5);
    check("R6 data", 64'(bw_data), 32'hCAFE);
    do_send(4'd6, 1, 32'h64);
    do_return(4'd6, 0, 32'h77, 4'd6);
    check_credits("R9 priority");
  endtask

  task automatic t_underflow;
    for (int k = 0; k < 5; k++) begin
      do_read(4'd4, 0, 4'(k), 32'h200 + 32'(k), 1);
      do_send(4'd4, 0, 32'h200 + 32'(k));
      do_return(4'd4, 0, 32'(k), 4'(k));
    end
    check("R10 underflow set", 64'(cred_underflow), 1);
    check_credits("R10 drained");
    @(negedge clk);
    cr_rel_valid = 1; cr_rel_up = 0; cr_rel_node = 4'd4;
    @(negedge clk);
    cr_rel_up = 1; cr_rel_node = 4'd8;
    @(negedge clk);
    cr_rel_valid = 0;
    exp_dn[0]++;
    if (exp_up[4] < 7) exp_up[4]++;
    check_credits("R9 release");
    check("R10 sticky after release", 64'(cred_underflow), 1);
  endtask

  initial begin
    for (int i = 0; i < NODES; i++) begin exp_dn[i] = INIT; exp_up[i] = INIT; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_window();
    t_order();
    t_priority();
    t_underflow();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule